// File: doc/BRIEF.md
# Floating-Point Control and Status Word Unit

This block keeps the two 16-bit housekeeping words of a floating-point unit. The control word carries six exception masks and the rounding and precision selects. The status word carries six sticky exception flags, a stack-fault bit, a summary bit, four condition codes, a three-bit top-of-stack index and a busy bit. Execution logic drives single-cycle exception events, condition-code writes, top-of-stack writes and a busy indication into the unit. The unit turns any set flag whose mask is clear into an interrupt request.

A command port accepts five operations: load the control word, read back the control word, read back the status word, clear the exception state and initialise. Each operation has a checking variant. When an unmasked flag is pending, a checking command is refused with a stall indication and has no effect. A non-checking command always executes. Read-backs return a registered result one cycle after the command. The returned value is the word as it stands after that cycle's updates.

Top module: `fcsw_unit`

## Requirements
- R1: After reset the control word is 037Fh, the status word is 0000h, and both `irq` and `rd_valid` are low.
- R2: A 1 on `exc_evt[i]` sets status bit i on the next clock edge whatever the mask holds. Bit 0 is invalid operation, bit 1 denormal, bit 2 zero-divide, bit 3 overflow, bit 4 underflow and bit 5 precision. A set flag stays set until an executed clear or initialise.
- R3: A pulse on `stk_fault_evt` sets status bit 6. Status bit 7 always equals the OR of status bits 0 to 5.
- R4: `irq` is high in exactly those cycles in which some status bit i (0..5) is 1 while control bit i is 0.
- R5: An executed load (`cmd_op`=1) writes all 16 bits of `cmd_data` into the control word, including reserved bits 6, 7 and 12..15, which read back as written and affect nothing. `round_mode` shows control bits 11:10 and `prec_mode` shows bits 9:8.
- R6: A load that clears the mask of an already-set flag makes `irq` high in the cycle after the load, before any further command is accepted.
- R7: An executed clear (`cmd_op`=4) zeroes status bits 0..7 and bit 15. The condition codes and the top-of-stack index are kept.
- R8: An executed initialise (`cmd_op`=5) sets the control word to 037Fh and the status word to 0000h.
- R9: A checking command (`cmd_chk`=1) issued while `irq` is high raises `cmd_stall` in the same cycle and changes neither word. With `irq` low it acts exactly like its non-checking form. `cmd_op` values 0, 6 and 7 do nothing.
- R10: An executed control read (`cmd_op`=2) or status read (`cmd_op`=3) raises `rd_valid` for one cycle on the next cycle. `rd_data` then holds that word's value after the command cycle's updates.
- R11: With `cc_we`, `cc_in[0..3]` is written to status bits 8, 9, 10 and 14. With `tos_we`, `tos_in` is written to status bits 13:11. `busy_set` sets status bit 15.
- R12: Execution updates in the same cycle as a command are applied after that command's effect, so an event arriving with a clear or initialise leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 1 load ctrl, 2 read ctrl, 3 read status, 4 clear, 5 initialise |
| cmd_chk | input | 1 | Checking variant of the command |
| cmd_data | input | 16 | Control word for a load |
| cmd_stall | output | 1 | Checking command refused this cycle |
| exc_evt | input | 6 | Exception event pulses |
| stk_fault_evt | input | 1 | Stack fault event pulse |
| busy_set | input | 1 | Sets the busy bit |
| cc_we | input | 1 | Condition-code write enable |
| cc_in | input | 4 | Condition codes C0..C3 |
| tos_we | input | 1 | Top-of-stack write enable |
| tos_in | input | 3 | New top-of-stack index |
| ctrl_word | output | 16 | Current control word |
| stat_word | output | 16 | Current status word |
| irq | output | 1 | Unmasked exception pending |
| round_mode | output | 2 | Rounding select field |
| prec_mode | output | 2 | Precision select field |
| rd_valid | output | 1 | Read-back data valid |
| rd_data | output | 16 | Read-back data |

## Verification
The bench builds the unit with its default reset control word of 037Fh, so after reset every exception starts masked. In that state, flags set by events leave `irq` low until a load opens a mask. Random loads move the masks freely. Random events, clears and initialises then produce the cases where a checking command meets a pending flag, and where an event lands in the same cycle as a clear or initialise.

// File: rtl/fcsw_pkg.sv
// Shared field positions, command codes and constants for the
// floating-point control/status word unit.
package fcsw_pkg;
    localparam int WORD_W    = 16;
    localparam int EXC_N     = 6;
    localparam int CC_N      = 4;
    localparam int TOS_W     = 3;
    // status word positions
    localparam int SB_SF     = 6;
    localparam int SB_SUM    = 7;
    localparam int SB_C0     = 8;
    localparam int SB_C1     = 9;
    localparam int SB_C2     = 10;
    localparam int SB_TOS_LO = 11;
    localparam int SB_C3     = 14;
    localparam int SB_BUSY   = 15;
    // control word positions
    localparam int CB_PREC_LO = 8;
    localparam int CB_RND_LO  = 10;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_LDCW = 3'd1,
        OP_STCW = 3'd2,
        OP_STSW = 3'd3,
        OP_CLEX = 3'd4,
        OP_INIT = 3'd5
    } op_e;

    localparam logic [WORD_W-1:0] CW_DEFAULT = 16'h037F;
endpackage

// File: rtl/fcsw_cmd_dec.sv
// Command decoder. Turns a command into one-hot action strobes.
// A checking command is refused (stall) while an unmasked flag is
// pending. Assumes `pending` comes from registered state only.
module fcsw_cmd_dec
    import fcsw_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       cmd_chk,
    input  logic       pending,
    output logic       stall,
    output logic       do_ld,
    output logic       do_stcw,
    output logic       do_stsw,
    output logic       do_clr,
    output logic       do_init
);
    logic accept;

    // Refuse checking commands while an exception waits.
    always_comb begin
        stall  = cmd_valid & cmd_chk & pending;
        accept = cmd_valid & ~stall;
    end

    // Decode the accepted operation.
    always_comb begin
        do_ld   = 1'b0;
        do_stcw = 1'b0;
        do_stsw = 1'b0;
        do_clr  = 1'b0;
        do_init = 1'b0;
        if (accept) begin
            case (op_e'(cmd_op))
                OP_LDCW: do_ld   = 1'b1;
                OP_STCW: do_stcw = 1'b1;
                OP_STSW: do_stsw = 1'b1;
                OP_CLEX: do_clr  = 1'b1;
                OP_INIT: do_init = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fcsw_ctrl_reg.sv
// Control word register. Loaded whole by a load command, forced to the
// default by initialise. Reserved bits are stored but feed no logic.
module fcsw_ctrl_reg
    import fcsw_pkg::*;
#(
    parameter logic [WORD_W-1:0] INIT_CW = CW_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_ld,
    input  logic              do_init,
    input  logic [WORD_W-1:0] ld_data,
    output logic [WORD_W-1:0] cw_q,
    output logic [WORD_W-1:0] cw_nxt
);
    // Next-value selection; initialise and load are exclusive.
    always_comb begin
        cw_nxt = cw_q;
        if (do_init)    cw_nxt = INIT_CW;
        else if (do_ld) cw_nxt = ld_data;
    end

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) cw_q <= INIT_CW;
        else        cw_q <= cw_nxt;
    end
endmodule

// File: rtl/fcsw_stat_reg.sv
// Status word register. Exception flags are sticky per bit and ignore
// the masks. Command effects (clear/initialise) are applied first and
// execution updates on top, so no same-cycle event is lost.
module fcsw_stat_reg
    import fcsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_clr,
    input  logic              do_init,
    input  logic [EXC_N-1:0]  exc_evt,
    input  logic              sf_evt,
    input  logic              busy_set,
    input  logic              cc_we,
    input  logic [CC_N-1:0]   cc_in,
    input  logic              tos_we,
    input  logic [TOS_W-1:0]  tos_in,
    output logic [WORD_W-1:0] sw_q,
    output logic [WORD_W-1:0] sw_nxt
);
    logic              wipe;
    logic [EXC_N-1:0]  flag_q, flag_nxt;
    logic              sf_q, sf_nxt;
    logic              sum_q, sum_nxt;
    logic              busy_q, busy_nxt;
    logic [CC_N-1:0]   cc_q, cc_nxt;
    logic [TOS_W-1:0]  tos_q, tos_nxt;

    // Clear and initialise both wipe the exception state.
    always_comb wipe = do_clr | do_init;

    // One sticky flag per exception class.
    for (genvar i = 0; i < EXC_N; i++) begin : g_flag
        always_comb flag_nxt[i] = (flag_q[i] & ~wipe) | exc_evt[i];
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= flag_nxt[i];
        end
    end

    // Next values of the non-flag fields.
    always_comb begin
        sf_nxt   = (sf_q & ~wipe) | sf_evt;
        busy_nxt = (busy_q & ~wipe) | busy_set;
        sum_nxt  = |flag_nxt;
        cc_nxt   = cc_we  ? cc_in  : (do_init ? '0 : cc_q);
        tos_nxt  = tos_we ? tos_in : (do_init ? '0 : tos_q);
    end

    // Storage of the non-flag fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sf_q   <= 1'b0;
            busy_q <= 1'b0;
            sum_q  <= 1'b0;
            cc_q   <= '0;
            tos_q  <= '0;
        end else begin
            sf_q   <= sf_nxt;
            busy_q <= busy_nxt;
            sum_q  <= sum_nxt;
            cc_q   <= cc_nxt;
            tos_q  <= tos_nxt;
        end
    end

    // Assemble the current and next status words.
    always_comb begin
        sw_q = '0;
        sw_q[EXC_N-1:0]                 = flag_q;
        sw_q[SB_SF]                     = sf_q;
        sw_q[SB_SUM]                    = sum_q;
        sw_q[SB_C0]                     = cc_q[0];
        sw_q[SB_C1]                     = cc_q[1];
        sw_q[SB_C2]                     = cc_q[2];
        sw_q[SB_TOS_LO+TOS_W-1:SB_TOS_LO] = tos_q;
        sw_q[SB_C3]                     = cc_q[3];
        sw_q[SB_BUSY]                   = busy_q;

        sw_nxt = '0;
        sw_nxt[EXC_N-1:0]                 = flag_nxt;
        sw_nxt[SB_SF]                     = sf_nxt;
        sw_nxt[SB_SUM]                    = sum_nxt;
        sw_nxt[SB_C0]                     = cc_nxt[0];
        sw_nxt[SB_C1]                     = cc_nxt[1];
        sw_nxt[SB_C2]                     = cc_nxt[2];
        sw_nxt[SB_TOS_LO+TOS_W-1:SB_TOS_LO] = tos_nxt;
        sw_nxt[SB_C3]                     = cc_nxt[3];
        sw_nxt[SB_BUSY]                   = busy_nxt;
    end
endmodule

// File: rtl/fcsw_irq_gen.sv
// Interrupt request: any flag whose mask bit is clear. Works from the
// registered words, so a mask opened by a load shows the cycle after.
module fcsw_irq_gen
    import fcsw_pkg::*;
(
    input  logic [EXC_N-1:0] flags,
    input  logic [EXC_N-1:0] masks,
    output logic             pending
);
    // Reduce the unmasked flags to one request.
    always_comb pending = |(flags & ~masks);
endmodule

// File: rtl/fcsw_unit.sv
// Top of the control/status word unit. Wires decoder, both word
// registers and the request logic, and registers read-back data.
// Assumes at most one command per cycle on the command port.
module fcsw_unit
    import fcsw_pkg::*;
#(
    parameter logic [15:0] INIT_CW = CW_DEFAULT
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  logic        cmd_chk,
    input  logic [15:0] cmd_data,
    output logic        cmd_stall,
    input  logic [5:0]  exc_evt,
    input  logic        stk_fault_evt,
    input  logic        busy_set,
    input  logic        cc_we,
    input  logic [3:0]  cc_in,
    input  logic        tos_we,
    input  logic [2:0]  tos_in,
    output logic [15:0] ctrl_word,
    output logic [15:0] stat_word,
    output logic        irq,
    output logic [1:0]  round_mode,
    output logic [1:0]  prec_mode,
    output logic        rd_valid,
    output logic [15:0] rd_data
);
    logic              do_ld, do_stcw, do_stsw, do_clr, do_init;
    logic              pending;
    logic [WORD_W-1:0] cw_q, cw_nxt, sw_q, sw_nxt;

    fcsw_cmd_dec u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_chk   (cmd_chk),
        .pending   (pending),
        .stall     (cmd_stall),
        .do_ld     (do_ld),
        .do_stcw   (do_stcw),
        .do_stsw   (do_stsw),
        .do_clr    (do_clr),
        .do_init   (do_init)
    );

    fcsw_ctrl_reg #(.INIT_CW(INIT_CW)) u_cw (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_ld   (do_ld),
        .do_init (do_init),
        .ld_data (cmd_data),
        .cw_q    (cw_q),
        .cw_nxt  (cw_nxt)
    );

    fcsw_stat_reg u_sw (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_clr   (do_clr),
        .do_init  (do_init),
        .exc_evt  (exc_evt),
        .sf_evt   (stk_fault_evt),
        .busy_set (busy_set),
        .cc_we    (cc_we),
        .cc_in    (cc_in),
        .tos_we   (tos_we),
        .tos_in   (tos_in),
        .sw_q     (sw_q),
        .sw_nxt   (sw_nxt)
    );

    fcsw_irq_gen u_irq (
        .flags   (sw_q[EXC_N-1:0]),
        .masks   (cw_q[EXC_N-1:0]),
        .pending (pending)
    );

    // Drive the word, field and request outputs.
    always_comb begin
        ctrl_word  = cw_q;
        stat_word  = sw_q;
        irq        = pending;
        round_mode = cw_q[CB_RND_LO+1:CB_RND_LO];
        prec_mode  = cw_q[CB_PREC_LO+1:CB_PREC_LO];
    end

    // Register read-back of the post-update word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= do_stcw | do_stsw;
            if (do_stcw)      rd_data <= cw_nxt;
            else if (do_stsw) rd_data <= sw_nxt;
        end
    end
endmodule

// File: rtl/fcsw_unit_chk.sv
// Property checker for fcsw_unit, bound to every instance of it.
module fcsw_unit_chk
    import fcsw_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [2:0]  cmd_op,
    input logic        cmd_chk,
    input logic [15:0] cmd_data,
    input logic        cmd_stall,
    input logic [5:0]  exc_evt,
    input logic        stk_fault_evt,
    input logic [15:0] ctrl_word,
    input logic [15:0] stat_word,
    input logic        irq
);
    p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_evt != 6'd0) |=> ((stat_word[5:0] & $past(exc_evt)) == $past(exc_evt)));

    p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_word[5:0]) & ~stat_word[5:0]) != 6'd0) |->
        $past(cmd_valid && !cmd_stall && (cmd_op == 3'd4 || cmd_op == 3'd5)));

    p_sf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stk_fault_evt |=> stat_word[6]);

    p_summary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[7] == (|stat_word[5:0]));

    p_unmask_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_stall && cmd_op == 3'd1 &&
         ((stat_word[5:0] & ~cmd_data[5:0]) != 6'd0)) |=> irq);

    p_init_cw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_stall && cmd_op == 3'd5) |=> (ctrl_word == 16'h037F));

    p_stall_when_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_chk && irq) |-> cmd_stall);

    p_stall_keeps_cw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stall |=> $stable(ctrl_word));
endmodule

bind fcsw_unit fcsw_unit_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_chk       (cmd_chk),
    .cmd_data      (cmd_data),
    .cmd_stall     (cmd_stall),
    .exc_evt       (exc_evt),
    .stk_fault_evt (stk_fault_evt),
    .ctrl_word     (ctrl_word),
    .stat_word     (stat_word),
    .irq           (irq)
);

// File: tb/fcsw_unit_tb_top.sv
module fcsw_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic        cmd_chk = 1'b0;
    logic [15:0] cmd_data = 16'd0;
    logic        cmd_stall;
    logic [5:0]  exc_evt = 6'd0;
    logic        stk_fault_evt = 1'b0;
    logic        busy_set = 1'b0;
    logic        cc_we = 1'b0;
    logic [3:0]  cc_in = 4'd0;
    logic        tos_we = 1'b0;
    logic [2:0]  tos_in = 3'd0;
    logic [15:0] ctrl_word, stat_word, rd_data;
    logic        irq, rd_valid;
    logic [1:0]  round_mode, prec_mode;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model state
    logic [15:0] m_cw = 16'h037F;
    logic [15:0] m_sw = 16'h0000;
    logic        m_rdv = 1'b0;
    logic [15:0] m_rdd = 16'h0000;

    always #5 clk = ~clk;

    fcsw_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_chk(cmd_chk), .cmd_data(cmd_data), .cmd_stall(cmd_stall),
        .exc_evt(exc_evt), .stk_fault_evt(stk_fault_evt), .busy_set(busy_set),
        .cc_we(cc_we), .cc_in(cc_in), .tos_we(tos_we), .tos_in(tos_in),
        .ctrl_word(ctrl_word), .stat_word(stat_word), .irq(irq),
        .round_mode(round_mode), .prec_mode(prec_mode),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic pend_of(input logic [15:0] cw, input logic [15:0] sw);
        return |(sw[5:0] & ~cw[5:0]);
    endfunction

    // One clock of stimulus, model update and comparison.
    task automatic cyc(input string tag, input logic v, input logic [2:0] op,
                       input logic ck, input logic [15:0] d, input logic [5:0] ev,
                       input logic sf, input logic bs, input logic cwe,
                       input logic [3:0] cc, input logic tw, input logic [2:0] tv);
        logic exe, st;
        logic [15:0] cw_n, sw_n;
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_chk = ck; cmd_data = d;
        exc_evt = ev; stk_fault_evt = sf; busy_set = bs;
        cc_we = cwe; cc_in = cc; tos_we = tw; tos_in = tv;
        #1;
        st = v & ck & pend_of(m_cw, m_sw);
        chk(tag, "stall", {15'd0, cmd_stall}, {15'd0, st});
        exe = v & ~st;
        cw_n = m_cw; sw_n = m_sw;
        if (exe && op == 3'd1) cw_n = d;
        if (exe && op == 3'd5) begin cw_n = 16'h037F; sw_n = 16'h0000; end
        if (exe && op == 3'd4) sw_n = sw_n & ~16'h80FF;
        sw_n[5:0] = sw_n[5:0] | ev;
        if (sf) sw_n[6] = 1'b1;
        if (bs) sw_n[15] = 1'b1;
        if (cwe) begin sw_n[8] = cc[0]; sw_n[9] = cc[1]; sw_n[10] = cc[2]; sw_n[14] = cc[3]; end
        if (tw) sw_n[13:11] = tv;
        sw_n[7] = |sw_n[5:0];
        m_rdv = exe && (op == 3'd2 || op == 3'd3);
        if (exe && op == 3'd2) m_rdd = cw_n;
        if (exe && op == 3'd3) m_rdd = sw_n;
        m_cw = cw_n; m_sw = sw_n;
        @(posedge clk);
        #1;
        chk(tag, "ctrl_word", ctrl_word, m_cw);
        chk(tag, "stat_word", stat_word, m_sw);
        chk(tag, "irq", {15'd0, irq}, {15'd0, pend_of(m_cw, m_sw)});
        chk(tag, "round_mode", {14'd0, round_mode}, {14'd0, m_cw[11:10]});
        chk(tag, "prec_mode", {14'd0, prec_mode}, {14'd0, m_cw[9:8]});
        chk(tag, "rd_valid", {15'd0, rd_valid}, {15'd0, m_rdv});
        if (m_rdv) chk(tag, "rd_data", rd_data, m_rdd);
    endtask

    task automatic idle(input string tag);
        cyc(tag, 1'b0, 3'd0, 1'b0, 16'd0, 6'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "ctrl_word", ctrl_word, 16'h037F);
        chk("R1", "stat_word", stat_word, 16'h0000);
        chk("R1", "irq", {15'd0, irq}, 16'd0);
        chk("R1", "rd_valid", {15'd0, rd_valid}, 16'd0);

        // R2 precision event while masked sets the flag, no request
        cyc("R2", 1'b0, 3'd0, 1'b0, 16'd0, 6'b100000, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0);
        // R3 stack fault and summary
        cyc("R3", 1'b0, 3'd0, 1'b0, 16'd0, 6'd0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0);
        // R5 load with reserved bits, all masks set
        cyc("R5", 1'b1, 3'd1, 1'b0, 16'hFBFF, 6'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0);
        // R6 open the precision mask while its flag is set
        cyc("R6", 1'b1, 3'd1, 1'b0, 16'hFCDF, 6'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0);
        // R4 request held while the unmasked flag stays set
        idle("R4");
        // R9 checking clear refused
        cyc("R9", 1'b1, 3'd4, 1'b1, 16'd0, 6'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0);
        // R10 status read-back, plus control read-back
        cyc("R10", 1'b1, 3'd3, 1'b0, 16'd0, 6'b000001, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0);
        cyc("R10", 1'b1, 3'd2, 1'b0, 16'd0, 6'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0);
        // R11 condition codes, top of stack, busy
        cyc("R11", 1'b0, 3'd0, 1'b0, 16'd0, 6'd0, 1'b0, 1'b1, 1'b1, 4'b1010, 1'b1, 3'd5);
        // R12 event together with a clear survives
        cyc("R12", 1'b1, 3'd4, 1'b0, 16'd0, 6'b000010, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0);
        // R7 plain clear keeps codes and index
        cyc("R7", 1'b1, 3'd4, 1'b0, 16'd0, 6'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0);
        // R8 initialise after dirtying both words
        cyc("R8", 1'b1, 3'd1, 1'b0, 16'h0C00, 6'b001000, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 3'd0);
        cyc("R8", 1'b1, 3'd5, 1'b0, 16'd0, 6'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0);
        // R9 checking load with nothing pending executes
        cyc("R9", 1'b1, 3'd1, 1'b1, 16'h0000, 6'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0);
        cyc("R4", 1'b0, 3'd0, 1'b0, 16'd0, 6'b000001, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0);
        cyc("R9", 1'b1, 3'd3, 1'b1, 16'd0, 6'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0);
        cyc("R9", 1'b1, 3'd7, 1'b0, 16'hFFFF, 6'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0);
        cyc("R8", 1'b1, 3'd5, 1'b0, 16'd0, 6'b010000, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0);

        // constrained random mix, R12 covers interaction of all fields
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] ev;
            ev = 6'($urandom()) & 6'($urandom()) & 6'($urandom());
            cyc("R12", 1'($urandom() % 2), 3'($urandom()), 1'($urandom()),
                16'($urandom()), ev, ($urandom() % 8) == 0, ($urandom() % 8) == 0,
                1'($urandom()), 4'($urandom()), 1'($urandom()), 3'($urandom()));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule